// File: doc/BRIEF.md
# Indexed Effective Address Sequencer

This block forms operand addresses for an 8-bit processor that has a 16-bit address space. It accepts one addressing command at a time. A command carries a mode, an access kind and the two index register values. The block then fetches the operand bytes at its own program counter and combines them with an index or with a pointer read from memory. It drives every bus cycle the real machine spends on the command, including the throw-away reads and writes that the hardware issues. When the sequence is complete it pulses `done` with the effective address. For immediate, read and read-modify-write commands it also returns the value that was fetched.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command whose `cmd_valid` is high must hold every command field until a rising edge sees both `cmd_valid` and `cmd_ready` high. `wr_data` must stay stable from acceptance until `done`.

The memory port carries one access per cycle. The port completes an access on a rising edge when both `bus_valid` and `bus_ready` are high. While `bus_ready` is low, the block freezes its state and keeps the same access on the bus. Read data is taken from `bus_rdata` in the cycle that completes the access.

Top module: `idx_addr_seq`

## Requirements
- R1: A command is taken on a rising edge with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is high only while no access is on the bus and `done` is low. The mode codes are 0 immediate, 1 zero page, 2 zero page+X, 3 zero page+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 (zp,X), 8 (zp),Y and 9 indirect jump. The kind codes are 0 read, 1 write and 2 read-modify-write. After reset `pc` equals RESET_PC.
- R2: Each operand byte is read at `pc` with tag 1 (operand fetch), and `pc` advances by one for each such byte. Two-byte operands and pointers are assembled low byte first, with the low byte at the lower address. The other tag codes are 2 data read, 3 data write, 4 dummy read and 5 dummy write. `bus_we` is high exactly for tags 3 and 5.
- R3: At most one access is presented per cycle. While `bus_valid` is high and `bus_ready` is low, the next cycle shows the same address, tag and write strobe.
- R4: Zero page+X and zero page+Y first issue a dummy read at the unindexed zero-page address. The index is then added with 8-bit wrap inside page 0.
- R5: For absolute+X and absolute+Y, a page cross means the upper byte of base+index differs from the upper byte of base. A read command issues a dummy read only on a page cross, at the base upper byte joined to the low-byte sum. Write and read-modify-write commands always issue that dummy read.
- R6: (zp,X) issues a dummy read at the zero-page byte before X is added. It then reads the pointer at zp+X, and when that location is 0xFF the upper pointer byte comes from 0x0000.
- R7: (zp),Y reads its pointer with the same 0xFF-to-0x0000 wrap. It then adds Y and applies the dummy-read rule of R5.
- R8: The indirect jump reads its target at the pointer. The upper target byte comes from the pointer with only its low byte incremented, so pointer xxFF takes it from xx00. `done_addr` is the target, and no data access follows.
- R9: A read-modify-write command reads the value at the effective address. It then writes that same value back with tag 5, and then writes `wr_data` there with tag 3.
- R10: `done` is high for exactly one cycle, in the cycle after the final access completes. It carries the effective address in `done_addr`. For immediate mode that address is the address of the immediate byte. `done_data` holds the fetched value for immediate, read and read-modify-write commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, accepts command |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_kind | input | 2 | Access kind code |
| cmd_x | input | 8 | X index value |
| cmd_y | input | 8 | Y index value |
| wr_data | input | 8 | Value for the final write |
| bus_valid | output | 1 | An access is presented |
| bus_ready | input | 1 | Memory completes the access this cycle |
| bus_addr | output | 16 | Access address |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_tag | output | 3 | Access type code |
| pc | output | 16 | Program counter |
| done | output | 1 | Command finished pulse |
| done_addr | output | 16 | Effective address |
| done_data | output | 8 | Fetched value |

## Verification
The bench builds the block with RESET_PC = 0xFFF6, so the operand fetches of the early directed commands cross the top of memory and wrap to 0x0000. The same directed set places pointers at 0x00FF and at 0x02FF, and it chooses index values that both cross and stay inside a page. A stalling memory drops `bus_ready` on about a quarter of the cycles, which exercises the hold behaviour in every state.

// File: rtl/idx_addr_seq_pkg.sv
package idx_addr_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [3:0] {
    M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3, M_ABS = 4'd4,
    M_ABSX = 4'd5, M_ABSY = 4'd6, M_INDX = 4'd7, M_INDY = 4'd8, M_JIND = 4'd9
  } mode_e;

  typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_RMW = 2'd2} kind_e;

  typedef enum logic [2:0] {
    T_NONE = 3'd0, T_OPND = 3'd1, T_DRD = 3'd2, T_DWR = 3'd3,
    T_DUMR = 3'd4, T_DUMW = 3'd5
  } tag_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OP1, S_OP2, S_ZDUM, S_PLO, S_PHI, S_FIX, S_RD, S_DUMW, S_WR, S_FIN
  } st_e;
endpackage

// File: rtl/idx_addr_seq_ea.sv
module idx_addr_seq_ea
  import idx_addr_seq_pkg::*;
(
  input  mode_e              mode,
  input  logic [DATA_W-1:0]  b_lo,
  input  logic [DATA_W-1:0]  b_hi,
  input  logic [DATA_W-1:0]  x,
  input  logic [DATA_W-1:0]  y,
  output logic [DATA_W-1:0]  idx,
  output logic [ADDR_W-1:0]  ea,
  output logic [ADDR_W-1:0]  fix_addr
);
  logic [DATA_W-1:0] lo_sum;

  always_comb begin
    case (mode)
      M_ZPX, M_ABSX:         idx = x;
      M_ZPY, M_ABSY, M_INDY: idx = y;
      default:               idx = '0;
    endcase
    lo_sum = b_lo + idx;
    if (mode == M_ZPX || mode == M_ZPY)
      ea = {{DATA_W{1'b0}}, lo_sum};
    else
      ea = {b_hi, b_lo} + {{DATA_W{1'b0}}, idx};
    fix_addr = {b_hi, lo_sum};
  end
endmodule

// File: rtl/idx_addr_seq_bus.sv
module idx_addr_seq_bus
  import idx_addr_seq_pkg::*;
(
  input  st_e                st,
  input  mode_e              mode,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [DATA_W-1:0]  b_lo,
  input  logic [DATA_W-1:0]  b_hi,
  input  logic [DATA_W-1:0]  x,
  input  logic [ADDR_W-1:0]  ea,
  input  logic [ADDR_W-1:0]  fix_addr,
  input  logic [DATA_W-1:0]  held,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               valid,
  output logic               we,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  wdata,
  output tag_e               tag
);
  logic [DATA_W-1:0] ptr_lo, ptr_hi, ptr_lo1;

  always_comb begin
    ptr_lo  = (mode == M_INDX) ? b_lo + x : b_lo;
    ptr_hi  = (mode == M_JIND) ? b_hi : '0;
    ptr_lo1 = ptr_lo + 1'b1;
    valid = 1'b1;
    we    = 1'b0;
    wdata = '0;
    addr  = '0;
    tag   = T_NONE;
    case (st)
      S_OP1, S_OP2: begin addr = pc;                           tag = T_OPND; end
      S_ZDUM:       begin addr = {{DATA_W{1'b0}}, b_lo};       tag = T_DUMR; end
      S_PLO:        begin addr = {ptr_hi, ptr_lo};             tag = T_DRD;  end
      S_PHI:        begin addr = {ptr_hi, ptr_lo1};            tag = T_DRD;  end
      S_FIX:        begin addr = fix_addr;                     tag = T_DUMR; end
      S_RD:         begin addr = ea;                           tag = T_DRD;  end
      S_DUMW:       begin addr = ea; we = 1'b1; wdata = held;  tag = T_DUMW; end
      S_WR:         begin addr = ea; we = 1'b1; wdata = wr_data; tag = T_DWR; end
      default:      valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq
  import idx_addr_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'hC000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_mode,
  input  logic [1:0]  cmd_kind,
  input  logic [7:0]  cmd_x,
  input  logic [7:0]  cmd_y,
  input  logic [7:0]  wr_data,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic [15:0] bus_addr,
  output logic        bus_we,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic [2:0]  bus_tag,
  output logic [15:0] pc,
  output logic        done,
  output logic [15:0] done_addr,
  output logic [7:0]  done_data
);
  st_e               st;
  mode_e             mode_q;
  kind_e             kind_q;
  logic [DATA_W-1:0] x_q, y_q, b_lo, b_hi, t_lo, held, idx;
  logic [ADDR_W-1:0] pc_q, ea, fix_addr;
  logic              hs, extra_rd;
  tag_e              tag;

  idx_addr_seq_ea u_ea (
    .mode(mode_q), .b_lo(b_lo), .b_hi(b_hi), .x(x_q), .y(y_q),
    .idx(idx), .ea(ea), .fix_addr(fix_addr)
  );

  idx_addr_seq_bus u_bus (
    .st(st), .mode(mode_q), .pc(pc_q), .b_lo(b_lo), .b_hi(b_hi), .x(x_q),
    .ea(ea), .fix_addr(fix_addr), .held(held), .wr_data(wr_data),
    .valid(bus_valid), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .tag(tag)
  );

  assign hs        = bus_valid & bus_ready;
  assign extra_rd  = (kind_q == K_WRITE) || (kind_q == K_RMW);
  assign bus_tag   = tag;
  assign pc        = pc_q;
  assign cmd_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign done_addr = ea;
  assign done_data = held;

  function automatic st_e data_phase(input kind_e k);
    return (k == K_WRITE) ? S_WR : S_RD;
  endfunction

  function automatic logic lo_carry(input logic [DATA_W-1:0] lo, input logic [DATA_W-1:0] ix);
    logic [DATA_W:0] s;
    s = {1'b0, lo} + {1'b0, ix};
    return s[DATA_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc_q   <= RESET_PC;
      mode_q <= M_IMM;
      kind_q <= K_READ;
      x_q    <= '0;
      y_q    <= '0;
      b_lo   <= '0;
      b_hi   <= '0;
      t_lo   <= '0;
      held   <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          mode_q <= mode_e'(cmd_mode);
          kind_q <= kind_e'(cmd_kind);
          x_q    <= cmd_x;
          y_q    <= cmd_y;
          st     <= S_OP1;
        end
        S_OP1: if (hs) begin
          pc_q <= pc_q + 1'b1;
          if (mode_q == M_IMM) begin
            {b_hi, b_lo} <= pc_q;
            held <= bus_rdata;
            st   <= S_FIN;
          end else begin
            b_lo <= bus_rdata;
            b_hi <= '0;
            case (mode_q)
              M_ZP:                 st <= data_phase(kind_q);
              M_ZPX, M_ZPY, M_INDX: st <= S_ZDUM;
              M_INDY:               st <= S_PLO;
              default:              st <= S_OP2;
            endcase
          end
        end
        S_OP2: if (hs) begin
          pc_q <= pc_q + 1'b1;
          b_hi <= bus_rdata;
          case (mode_q)
            M_ABSX, M_ABSY:
              st <= (extra_rd || lo_carry(b_lo, idx)) ? S_FIX : data_phase(kind_q);
            M_JIND:  st <= S_PLO;
            default: st <= data_phase(kind_q);
          endcase
        end
        S_ZDUM: if (hs) st <= (mode_q == M_INDX) ? S_PLO : data_phase(kind_q);
        S_PLO: if (hs) begin
          t_lo <= bus_rdata;
          st   <= S_PHI;
        end
        S_PHI: if (hs) begin
          b_lo <= t_lo;
          b_hi <= bus_rdata;
          case (mode_q)
            M_JIND:  st <= S_FIN;
            M_INDY:  st <= (extra_rd || lo_carry(t_lo, idx)) ? S_FIX : data_phase(kind_q);
            default: st <= data_phase(kind_q);
          endcase
        end
        S_FIX: if (hs) st <= data_phase(kind_q);
        S_RD: if (hs) begin
          held <= bus_rdata;
          st   <= (kind_q == K_RMW) ? S_DUMW : S_FIN;
        end
        S_DUMW: if (hs) st <= S_WR;
        S_WR:   if (hs) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_addr_seq_chk.sv
module idx_addr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [15:0] bus_addr,
  input logic        bus_we,
  input logic [2:0]  bus_tag,
  input logic [15:0] pc,
  input logic        done
);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_valid && !done));

  // R2
  opnd_at_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_tag == 3'd1) |-> (bus_addr == pc));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_tag == 3'd1) |=> (pc == $past(pc) + 16'd1));

  // R2
  we_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_we == (bus_tag == 3'd3 || bus_tag == 3'd5)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_tag) && $stable(bus_we)));

  // R9
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_tag == 3'd5) |=>
      (bus_valid && bus_tag == 3'd3 && bus_addr == $past(bus_addr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

bind idx_addr_seq idx_addr_seq_chk u_chk (.*);

// File: tb/tb_idx_addr_seq.sv
module tb_idx_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START_PC = 16'hFFF6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [3:0] cmd_mode = '0;
  logic [1:0] cmd_kind = '0;
  logic [7:0] cmd_x = '0, cmd_y = '0, wr_data = '0;
  logic bus_valid, bus_ready = 1'b0, bus_we;
  logic [15:0] bus_addr, pc, done_addr;
  logic [7:0] bus_wdata, bus_rdata = '0, done_data;
  logic [2:0] bus_tag;
  logic done;

  idx_addr_seq #(.RESET_PC(START_PC)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] ov_a [8];
  logic [7:0]  ov_v [8];
  int ov_n = 0;
  logic [15:0] e_a [16], o_a [16];
  logic [2:0]  e_t [16], o_t [16];
  logic        e_w [16], o_w [16];
  logic [7:0]  e_d [16], o_d [16];
  int e_n, o_n;
  logic [15:0] exp_ea, pc_m;
  logic [7:0]  exp_data;
  logic got_done = 1'b0, prev_stall = 1'b0;
  logic [15:0] got_addr, prev_addr;
  logic [7:0]  got_data;
  logic [2:0]  prev_tag;
  int cycles = 0;
  logic summary_done = 1'b0;

  function automatic logic [7:0] memrd(input logic [15:0] a);
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) return ov_v[i];
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (prev_stall)
        check(bus_valid && bus_addr == prev_addr && bus_tag == prev_tag, "R3",
              "stall hold", {13'd0, bus_tag, bus_addr}, {13'd0, prev_tag, prev_addr});
      bus_ready = ($urandom % 4) != 0;
      bus_rdata = memrd(bus_addr);
      prev_stall = bus_valid && !bus_ready;
      prev_addr = bus_addr;
      prev_tag = bus_tag;
      if (bus_valid && bus_ready && o_n < 16) begin
        o_a[o_n] = bus_addr; o_t[o_n] = bus_tag; o_w[o_n] = bus_we;
        o_d[o_n] = bus_wdata; o_n++;
      end
      if (done) begin got_done = 1'b1; got_addr = done_addr; got_data = done_data; end
    end
  end

  task automatic push(input logic [15:0] a, input logic [2:0] t, input logic w, input logic [7:0] d);
    e_a[e_n] = a; e_t[e_n] = t; e_w[e_n] = w; e_d[e_n] = d; e_n++;
  endtask

  task automatic model(input int mode, input int kind, input logic [7:0] x,
                       input logic [7:0] y, input logic [7:0] wd);
    logic [15:0] base;
    logic [7:0] lo, hi, q, ix;
    bit data_ph;
    e_n = 0; data_ph = 1;
    ix = (mode == 5) ? x : y;
    push(pc_m, 3'd1, 0, 0); lo = memrd(pc_m); pc_m++;
    case (mode)
      0: begin exp_ea = pc_m - 16'd1; exp_data = lo; data_ph = 0; end
      1: exp_ea = {8'h00, lo};
      2, 3: begin push({8'h00, lo}, 3'd4, 0, 0);
                  exp_ea = {8'h00, lo + ((mode == 2) ? x : y)}; end
      7: begin push({8'h00, lo}, 3'd4, 0, 0); q = lo + x;
               push({8'h00, q}, 3'd2, 0, 0); push({8'h00, q + 8'd1}, 3'd2, 0, 0);
               exp_ea = {memrd({8'h00, q + 8'd1}), memrd({8'h00, q})}; end
      8: begin push({8'h00, lo}, 3'd2, 0, 0); push({8'h00, lo + 8'd1}, 3'd2, 0, 0);
               base = {memrd({8'h00, lo + 8'd1}), memrd({8'h00, lo})};
               exp_ea = base + {8'h00, ix};
               if (kind != 0 || exp_ea[15:8] != base[15:8])
                 push({base[15:8], exp_ea[7:0]}, 3'd4, 0, 0); end
      default: begin
        push(pc_m, 3'd1, 0, 0); hi = memrd(pc_m); pc_m++;
        base = {hi, lo};
        if (mode == 9) begin
          push(base, 3'd2, 0, 0); push({hi, lo + 8'd1}, 3'd2, 0, 0);
          exp_ea = {memrd({hi, lo + 8'd1}), memrd(base)}; data_ph = 0;
        end else if (mode == 5 || mode == 6) begin
          exp_ea = base + {8'h00, ix};
          if (kind != 0 || exp_ea[15:8] != base[15:8])
            push({base[15:8], exp_ea[7:0]}, 3'd4, 0, 0);
        end else exp_ea = base;
      end
    endcase
    if (data_ph) begin
      exp_data = memrd(exp_ea);
      if (kind == 1) push(exp_ea, 3'd3, 1, wd);
      else begin
        push(exp_ea, 3'd2, 0, 0);
        if (kind == 2) begin push(exp_ea, 3'd5, 1, exp_data); push(exp_ea, 3'd3, 1, wd); end
      end
    end
  endtask

  task automatic run_one(input int mode, input int kind, input logic [7:0] x, input logic [7:0] y);
    string req;
    int wait_n;
    logic [7:0] wd;
    wd = 8'($urandom);
    case (mode)
      2, 3: req = "R4";
      5, 6: req = "R5";
      7: req = "R6";
      8: req = "R7";
      9: req = "R8";
      default: req = (kind == 2) ? "R9" : "R2";
    endcase
    model(mode, kind, x, y, wd);
    @(negedge clk); #1;
    o_n = 0; got_done = 1'b0;
    cmd_mode = 4'(mode); cmd_kind = 2'(kind); cmd_x = x; cmd_y = y; wr_data = wd;
    cmd_valid = 1'b1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    check(!cmd_ready, "R1", "command taken", {31'd0, cmd_ready}, 32'd0);
    wait_n = 0;
    while (!got_done && wait_n < 300) begin @(negedge clk); #1; wait_n++; end
    check(got_done, "R10", "done seen", {31'd0, got_done}, 32'd1);
    check(o_n == e_n, req, "access count", o_n, e_n);
    for (int i = 0; i < e_n && i < o_n; i++)
      check(o_a[i] == e_a[i] && o_t[i] == e_t[i] && o_w[i] == e_w[i] &&
            (!e_w[i] || o_d[i] == e_d[i]), req, $sformatf("access %0d", i),
            {o_d[i], 4'(o_t[i]), 3'd0, o_w[i], o_a[i]}, {e_d[i], 4'(e_t[i]), 3'd0, e_w[i], e_a[i]});
    check(got_addr == exp_ea, (mode == 0) ? "R10" : req, "done_addr", got_addr, exp_ea);
    if (kind != 1 && mode != 9)
      check(got_data == exp_data, "R10", "done_data", got_data, exp_data);
    check(pc == pc_m, "R2", "pc after command", pc, pc_m);
  endtask

  task automatic ops(input logic [7:0] b0, input logic [7:0] b1);
    ov_a[0] = pc_m; ov_v[0] = b0; ov_a[1] = pc_m + 16'd1; ov_v[1] = b1; ov_n = 2;
  endtask

  task automatic add_ov(input logic [15:0] a, input logic [7:0] v);
    ov_a[ov_n] = a; ov_v[ov_n] = v; ov_n++;
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    pc_m = START_PC;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(cmd_ready && !bus_valid && !done, "R1", "reset idle",
          {29'd0, cmd_ready, bus_valid, done}, 32'h4);
    check(pc == START_PC, "R1", "reset pc", pc, START_PC);
    // R2 immediate
    ops(8'h3C, 8'h00); run_one(0, 0, 8'h00, 8'h00);
    // R4 zero page X wrap: F0+20 -> 0010
    ops(8'hF0, 8'h00); run_one(2, 0, 8'h20, 8'h00);
    // R5 absolute X read with page cross
    ops(8'hF0, 8'h12); run_one(5, 0, 8'h20, 8'h00);
    // R5 absolute X read, no cross, no dummy
    ops(8'h10, 8'h12); run_one(5, 0, 8'h20, 8'h00);
    // R5 absolute Y write always dummy
    ops(8'h10, 8'h12); run_one(6, 1, 8'h00, 8'h05);
    // R6 (zp,X) pointer at FF
    ops(8'hF0, 8'h00); add_ov(16'h00FF, 8'h34); add_ov(16'h0000, 8'h12);
    run_one(7, 0, 8'h0F, 8'h00);
    // R7 (zp),Y pointer at FF with cross
    ops(8'hFF, 8'h00); add_ov(16'h00FF, 8'h20); add_ov(16'h0000, 8'h30);
    run_one(8, 0, 8'h00, 8'hF0);
    // R8 indirect jump page bug
    ops(8'hFF, 8'h02); add_ov(16'h02FF, 8'h78); add_ov(16'h0200, 8'h56);
    run_one(9, 0, 8'h00, 8'h00);
    // R9 read-modify-write absolute and zero page Y
    ops(8'h00, 8'h40); run_one(4, 2, 8'h00, 8'h00);
    ops(8'hFE, 8'h00); run_one(3, 2, 8'h00, 8'h07);
    ov_n = 0;
    for (int i = 0; i < 60; i++)
      run_one(int'($urandom % 10), int'($urandom % 3), 8'($urandom), 8'($urandom));
    finish_run();
  end
endmodule